// File: doc/BRIEF.md
# Double-Buffered Compare Timer

This block is a free-running up counter with two compare channels. Software sets each compare value one byte at a time through a narrow write port. While the run input is high the counter advances once per clock. Each compare channel gives a one-cycle pulse when the counter reaches its value. Compare channel 1 also sets the counting period: when the counter equals that value, the counter returns to zero on the next counting edge.

Compare channel 0 has a staging (shadow) register in front of it. With the buffer-enable input low, a write to channel 0 goes through to both the staging register and the active compare value. With it high, writes reach only the staging register. The staged value is then copied into the active compare value on the edge where the counter wraps at channel 1. A new threshold can therefore be prepared at any point in a period and takes effect cleanly at the start of the next one.

The counter is sequenced by a small state machine:

- **States:**
  - `ST_HALT`: stopped; the counter is held at zero.
  - `ST_COUNT`: the last edge was an ordinary increment.
  - `ST_WRAP`: the last edge cleared the counter on a channel-1 match.
- **Transitions:**
  - Any state goes to `ST_HALT` when run is low.
  - Any state goes to `ST_WRAP` when run is high and the counter equals compare 1.
  - Any state goes to `ST_COUNT` when run is high and the counter differs from compare 1.
- **Output:** the channel-1 pulse is the `ST_WRAP` state.

Top module: `dbt_timer`

## Requirements
- R1: While reset is asserted, the counter reads 0 and both match pulses are low. The compare values and the staging register take the value all-ones.
- R2: If run is low at a clock edge, the counter reads 0 after that edge, and neither match pulse is raised for that edge.
- R3: If run is high at an edge and the counter differs from compare 1, the counter increases by exactly one at that edge, wrapping modulo 2^16.
- R4: If run is high at an edge and the counter equals compare 1, the counter reads 0 after that edge and `match1_o` is high for the following cycle only.
- R5: `match0_o` is high for the cycle after every edge where run is high and the counter equals compare 0, and low after every other edge.
- R6: Each compare value occupies two byte offsets: the low byte at the even offset and the high byte at the odd offset. Compare 0 uses offsets 0 and 1; compare 1 uses offsets 2 and 3. A write at an offset changes only that byte.
- R7: A byte write leaves the other byte of the same compare value unchanged.
- R8: With `buf_en_i` low, a write at offset 0 or 1 sets that byte in both the staging register and compare 0.
- R9: With `buf_en_i` high, a write at offset 0 or 1 changes only the staging register. Compare 0 keeps its value until the next channel-1 wrap.
- R10: With `buf_en_i` high, on an edge where run is high and the counter equals compare 1, compare 0 takes the staging register's value.
- R11: When a staging write and a wrap fall on the same edge, compare 0 receives the staging value from before the write, and the staging register keeps the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 2 | Byte offset of the write |
| wr_data_i | input | 8 | Byte to write |
| run_i | input | 1 | High: count; low: hold the counter at zero |
| buf_en_i | input | 1 | High: channel-0 writes go to the staging register only |
| count_o | output | 16 | Current counter value |
| match0_o | output | 1 | One-cycle pulse on a channel-0 match |
| match1_o | output | 1 | One-cycle pulse on a channel-1 match (counter wrap) |

## Verification
The bench aims a staging write at the exact edge where the counter wraps. A design that gave the new byte priority over the old staged value would load the wrong threshold, and `match0_o` would land in the wrong cycle of the next period. It changes a single byte of a compare value and times the match. If the other byte were lost, the period would collapse, or the counter would run on toward 65535 and miss its wrap.

With buffering enabled, it writes a new channel-0 value in the middle of a period. A design that let the write leak straight into compare 0 would pulse at the new value too early. It also drops run in the middle of a period and randomises writes, buffer-enable and run. A counter that paused instead of clearing, or a match pulse that lasted two cycles, would then differ from the behavioural model on the very next clock.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
    // Counter sequencing states: what the most recent clock edge did.
    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WRAP  = 2'd2
    } cnt_state_e;
endpackage

// File: rtl/dbt_regfile.sv
module dbt_regfile #(
    parameter int CW = 16,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [7:0]    wr_data_i,
    input  logic          buf_en_i,
    input  logic          load_i,
    output logic [CW-1:0] cmp0_o,
    output logic [CW-1:0] cmp1_o,
    output logic [CW-1:0] stage_o
);
    localparam int BYTES = CW / 8;

    logic [CW-1:0] cmp0_q;
    logic [CW-1:0] cmp1_q;
    logic [CW-1:0] stage_q;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        localparam logic [AW-1:0] OFF0 = AW'(b);
        localparam logic [AW-1:0] OFF1 = AW'(BYTES + b);

        logic hit0;
        logic hit1;
        assign hit0 = wr_en_i && (wr_addr_i == OFF0);
        assign hit1 = wr_en_i && (wr_addr_i == OFF1);

        // Staging byte: every write to the channel-0 offset lands here.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[8*b +: 8] <= 8'hFF;
            end else if (hit0) begin
                stage_q[8*b +: 8] <= wr_data_i;
            end
        end

        // Active channel-0 byte: written through when buffering is off,
        // otherwise loaded from the pre-edge staging byte on a wrap.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp0_q[8*b +: 8] <= 8'hFF;
            end else if (hit0 && !buf_en_i) begin
                cmp0_q[8*b +: 8] <= wr_data_i;
            end else if (load_i) begin
                cmp0_q[8*b +: 8] <= stage_q[8*b +: 8];
            end
        end

        // Channel-1 byte: plain write.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp1_q[8*b +: 8] <= 8'hFF;
            end else if (hit1) begin
                cmp1_q[8*b +: 8] <= wr_data_i;
            end
        end
    end

    assign cmp0_o  = cmp0_q;
    assign cmp1_o  = cmp1_q;
    assign stage_o = stage_q;
endmodule

// File: rtl/dbt_counter.sv
module dbt_counter
    import dbt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [CW-1:0] cmp1_i,
    output logic [CW-1:0] count_o,
    output logic          top_o,
    output logic          wrap_o
);
    cnt_state_e    state_q;
    cnt_state_e    state_d;
    logic [CW-1:0] count_q;
    logic          at_top;

    assign at_top = run_i && (count_q == cmp1_i);

    // Next-state decision.
    always_comb begin
        unique case (1'b1)
            !run_i:  state_d = ST_HALT;
            at_top:  state_d = ST_WRAP;
            default: state_d = ST_COUNT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter datapath, steered by the chosen transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (state_d)
                ST_COUNT: count_q <= count_q + CW'(1);
                ST_WRAP:  count_q <= '0;
                ST_HALT:  count_q <= '0;
                default:  count_q <= '0;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        wrap_o = 1'b0;
        unique case (state_q)
            ST_WRAP:  wrap_o = 1'b1;
            ST_COUNT: wrap_o = 1'b0;
            ST_HALT:  wrap_o = 1'b0;
            default:  wrap_o = 1'b0;
        endcase
    end

    assign count_o = count_q;
    assign top_o   = at_top;
endmodule

// File: rtl/dbt_match.sv
module dbt_match #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [CW-1:0] count_i,
    input  logic [CW-1:0] cmp_i,
    output logic          pulse_o
);
    logic pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= run_i && (count_i == cmp_i);
        end
    end

    assign pulse_o = pulse_q;
endmodule

// File: rtl/dbt_timer.sv
module dbt_timer #(
    parameter int CW = 16,
    parameter int AW = $clog2(2 * (CW / 8))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [7:0]    wr_data_i,
    input  logic          run_i,
    input  logic          buf_en_i,
    output logic [CW-1:0] count_o,
    output logic          match0_o,
    output logic          match1_o
);
    logic [CW-1:0] cmp0_q;
    logic [CW-1:0] cmp1_q;
    logic [CW-1:0] stage_q;
    logic          top;
    logic          load;

    assign load = buf_en_i && top;

    dbt_regfile #(.CW(CW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .buf_en_i  (buf_en_i),
        .load_i    (load),
        .cmp0_o    (cmp0_q),
        .cmp1_o    (cmp1_q),
        .stage_o   (stage_q)
    );

    dbt_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .cmp1_i  (cmp1_q),
        .count_o (count_o),
        .top_o   (top),
        .wrap_o  (match1_o)
    );

    dbt_match #(.CW(CW)) u_m0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .count_i (count_o),
        .cmp_i   (cmp0_q),
        .pulse_o (match0_o)
    );
endmodule

// File: rtl/dbt_timer_chk.sv
module dbt_timer_chk #(
    parameter int CW = 16,
    parameter int AW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en_i,
    input logic [AW-1:0] wr_addr_i,
    input logic [7:0]    wr_data_i,
    input logic          run_i,
    input logic          buf_en_i,
    input logic [CW-1:0] count_o,
    input logic          match0_o,
    input logic          match1_o,
    input logic [CW-1:0] cmp0_q,
    input logic [CW-1:0] cmp1_q,
    input logic [CW-1:0] stage_q
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0) && !match0_o && !match1_o);

    p_halt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (count_o == '0) && !match0_o && !match1_o);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (count_o != cmp1_q)) |=> (count_o == $past(count_o) + CW'(1)));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (count_o == cmp1_q)) |=> (count_o == '0) && match1_o);

    p_m0_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (count_o == cmp0_q)) |=> match0_o);

    p_m0_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_i && (count_o == cmp0_q)) |=> !match0_o);

    p_lo_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i == AW'(2))) |=>
            (cmp1_q[7:0] == $past(wr_data_i)) && (cmp1_q[CW-1:8] == $past(cmp1_q[CW-1:8])));

    p_other_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i == AW'(3))) |=>
            (cmp1_q[7:0] == $past(cmp1_q[7:0])) && (cmp1_q[15:8] == $past(wr_data_i)));

    p_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !buf_en_i && (wr_addr_i == AW'(0))) |=>
            (cmp0_q[7:0] == $past(wr_data_i)) && (stage_q[7:0] == $past(wr_data_i)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en_i && !(run_i && (count_o == cmp1_q))) |=> (cmp0_q == $past(cmp0_q)));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en_i && run_i && (count_o == cmp1_q)) |=> (cmp0_q == $past(stage_q)));

    p_same_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en_i && run_i && (count_o == cmp1_q) && wr_en_i && (wr_addr_i == AW'(0))) |=>
            (stage_q[7:0] == $past(wr_data_i)) && (cmp0_q == $past(stage_q)));
endmodule

bind dbt_timer dbt_timer_chk #(.CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .run_i     (run_i),
    .buf_en_i  (buf_en_i),
    .count_o   (count_o),
    .match0_o  (match0_o),
    .match1_o  (match1_o),
    .cmp0_q    (cmp0_q),
    .cmp1_q    (cmp1_q),
    .stage_q   (stage_q)
);

// File: tb/dbt_timer_tb.sv
module dbt_timer_tb;
    localparam int CW = 16;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          run = 1'b0;
    logic          buf_en = 1'b0;
    logic [CW-1:0] count;
    logic          match0;
    logic          match1;

    always #4 clk = ~clk;   // 125 MHz

    dbt_timer #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .run_i(run), .buf_en_i(buf_en),
        .count_o(count), .match0_o(match0), .match1_o(match1)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    logic [15:0] m_cnt, m_c0, m_c1, m_sh;
    logic        m_m0, m_m1;
    string       m_tag = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_c0 = 16'hFFFF; m_c1 = 16'hFFFF; m_sh = 16'hFFFF;
            m_m0 = 0; m_m1 = 0; m_tag = "R1";
        end else begin
            logic [15:0] nc0, nc1, nsh;
            logic top0, top1;
            top0 = run && (m_cnt == m_c0);
            top1 = run && (m_cnt == m_c1);
            nc0 = m_c0; nc1 = m_c1; nsh = m_sh;
            if (buf_en && top1) nc0 = m_sh;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin nsh[7:0] = wr_data;  if (!buf_en) nc0[7:0] = wr_data;  end
                    2'd1: begin nsh[15:8] = wr_data; if (!buf_en) nc0[15:8] = wr_data; end
                    2'd2: nc1[7:0] = wr_data;
                    default: nc1[15:8] = wr_data;
                endcase
            end
            m_tag = !run ? "R2" : (top1 ? "R4" : "R3");
            m_cnt = !run ? 16'd0 : (top1 ? 16'd0 : m_cnt + 16'd1);
            m_m0 = top0; m_m1 = top1;
            m_c0 = nc0; m_c1 = nc1; m_sh = nsh;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            chk(m_tag, "count", int'(count), int'(m_cnt));
            chk("R5", "match0", int'(match0), int'(m_m0));
            chk("R4", "match1", int'(match1), int'(m_m1));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic sel, input logic [15:0] v);
        wr({sel, 1'b0}, v[7:0]);
        wr({sel, 1'b1}, v[15:8]);
    endtask

    // Wait for a channel-0 pulse; the counter has then moved one past the value.
    task automatic wait_m0(input string tag, input int thr);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (match0) break;
        end
        chk(tag, "count at match0", int'(count), thr + 1);
    endtask

    task automatic wait_m1();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (match1) break;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "count in reset", int'(count), 0);
        chk("R1", "match0 in reset", int'(match0), 0);
        chk("R1", "match1 in reset", int'(match1), 0);
        rst_n = 1'b1;
        checking = 1'b1;

        // R6 / R8: period 20, threshold 5, written through.
        wr16(1'b1, 16'd20);
        wr16(1'b0, 16'd5);
        run = 1'b1;
        wait_m0("R8", 5);
        wait_m1();
        chk("R4", "count at wrap pulse", int'(count), 0);

        // R7: single low-byte writes keep the high byte (0).
        wr(2'd0, 8'd9);
        wr(2'd2, 8'd30);
        wait_m1();
        begin
            int gap = 0;
            do begin @(negedge clk); gap++; end while (!match1 && gap < 400);
            chk("R7", "period after low-byte write", gap, 31);
        end
        wait_m0("R7", 9);

        // R9 / R10: staged value waits for the wrap.
        buf_en = 1'b1;
        wait_m1();
        wr16(1'b0, 16'd11);
        wait_m0("R9", 9);
        wait_m1();
        wait_m0("R10", 11);

        // R11: staging write on the wrap edge itself.
        wr(2'd1, 8'd0);
        for (int i = 0; i < 100 && count != 16'd30; i++) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd17;
        @(negedge clk);
        wr_en = 1'b0;
        wait_m0("R11", 11);
        wait_m1();
        wait_m0("R11", 17);

        // R2: dropping run clears the counter.
        repeat (4) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk("R2", "count after stop", int'(count), 0);
        repeat (3) @(negedge clk);
        run = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3", "count after restart", int'(count), 5);

        // Randomised traffic under the cycle model.
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 5) == 0);
            wr_addr = 2'($urandom_range(0, 3));
            wr_data = wr_addr[0] ? 8'd0 : 8'($urandom_range(1, 40));
            if ($urandom_range(0, 60) == 0) buf_en = ~buf_en;
            run = ($urandom_range(0, 40) != 0);
        end
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        checking = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule